// File: doc/BRIEF.md
# Parallel Video Timing Generator

This block produces the control timing for a parallel pixel bus: horizontal sync, vertical sync, data-enable, a clock-inversion select, plus field and eye indicators and the current pixel and line counters. Horizontal timing is set by a sync width, a back porch, an active width and a front porch. Vertical timing comes from one of four parameter sets. Each set has its own sync width, back porch, front porch and half-line shift flag. The active line count is shared by all four sets.

A frame is made of segments. Each segment is one (eye, field) pair. Progressive output repeats a single segment. Interlaced output alternates an odd field and an even field. Stereo frame packing produces the left eye and then the right eye. When stereo and interlace are both on, the order is left-odd, right-odd, left-even, right-even.

Configuration is taken into an internal copy in two cases: on every cycle while the software reset is held, and on the last pixel of a frame. Software therefore either holds the reset while it reprograms the block, or lets a change take effect cleanly at the next frame. The enable input starts and stops output.

Top module: `video_tgen`

## Requirements
- R1: After rst_ni, and while sw_rst_i is high or en_i is low, the outputs are idle. In the idle state hcnt_o, vcnt_o, field_o and eye_o read 0, and hsync_o, vsync_o and de_o each equal their polarity bit. The outputs show idle two clock edges after the condition is sampled.
- R2: A line lasts hsw+hbp+hact+hfp pixel clocks. Horizontal sync is active while hcnt_o < hsw.
- R3: Data-enable is active only when hcnt_o is in [hsw+hbp, hsw+hbp+hact) and vcnt_o is in [vsw+vbp, vsw+vbp+vact), where vsw and vbp come from the current set. In interlaced mode vact is the line count of one field.
- R4: pol_i bit 0 drives pclk_inv_o, bit 1 inverts de, bit 2 inverts hsync and bit 3 inverts vsync. A 0 bit means active-high and a 1 bit means active-low.
- R5: After the block leaves idle, the first output cycle shows pixel 0 of line 0 in segment (eye 0, field 0). hcnt_o then increases by one per clock and wraps at the line end. vcnt_o wraps after vsw+vbp+vact+vfp lines of the current set.
- R6: With interlace_i high, field_o alternates 0 (odd) and 1 (even) from segment to segment. In progressive mode field_o stays 0.
- R7: Each set has a half-line flag. When the flag is clear, vsync is active for all of lines 0 to vsw-1. When the flag is set, vsync turns on at hcnt = floor(line_total/2) of line 0 and turns off at the same position of line vsw.
- R8: With stereo_i high, eye_o is 0 (left) and then 1 (right) within each field. The vertical set index is eye*2+field: 0 left-odd, 1 left-even, 2 right-odd, 3 right-even.
- R9: Asserting sw_rst_i, or dropping en_i, during output returns the block to idle. On release the block restarts from pixel 0 of line 0 of segment 0, using the configuration taken during the reset.
- R10: A configuration change made while the block runs with sw_rst_i low takes effect at the first pixel of the next frame, never part-way through a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Software reset: holds counters, loads configuration |
| en_i | input | 1 | Output enable |
| hsw_i | input | HW | Horizontal sync width |
| hbp_i | input | HW | Horizontal back porch |
| hfp_i | input | HW | Horizontal front porch |
| hact_i | input | HW | Active pixels per line |
| vact_i | input | VW | Active lines per segment |
| vsw_i | input | 4×VW | Vertical sync width per set |
| vbp_i | input | 4×VW | Vertical back porch per set |
| vfp_i | input | 4×VW | Vertical front porch per set |
| vhalf_i | input | 4 | Half-line vsync shift per set |
| interlace_i | input | 1 | Interlaced mode |
| stereo_i | input | 1 | Stereo frame-packed mode |
| pol_i | input | 4 | Polarity selects (clock, de, hsync, vsync) |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | 0 odd, 1 even field |
| eye_o | output | 1 | 0 left, 1 right eye |
| hcnt_o | output | HW+2 | Pixel counter |
| vcnt_o | output | VW+2 | Line counter |

## Verification
A wrong counter or segment state appears at the ports within one line. vcnt_o or field_o/eye_o steps at the wrong pixel, or sync and data-enable stop matching the programmed windows on the very next cycle. A wrong set selection shows up at the first segment change, as a vsync or data-enable window of the wrong length. A configuration picked up too early shows up as a line of the wrong length inside the frame in which the change was made. The bench runs an independent cycle model of counters, segments and windows and compares every output on every pixel.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  localparam int unsigned NUM_SETS = 4;
  localparam int unsigned POL_CLK  = 0;
  localparam int unsigned POL_DE   = 1;
  localparam int unsigned POL_HS   = 2;
  localparam int unsigned POL_VS   = 3;

  // vertical set index: {eye, field}
  function automatic logic [1:0] set_idx(input logic eye, input logic field);
    return {eye, field};
  endfunction
endpackage

// File: rtl/vtg_cfg_shadow.sv
`timescale 1ns/1ps
module vtg_cfg_shadow import vtg_pkg::*; #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [HW-1:0]                hsw_i,
  input  logic [HW-1:0]                hbp_i,
  input  logic [HW-1:0]                hfp_i,
  input  logic [HW-1:0]                hact_i,
  input  logic [VW-1:0]                vact_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vsw_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vbp_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vfp_i,
  input  logic [NUM_SETS-1:0]          vhalf_i,
  input  logic                         interlace_i,
  input  logic                         stereo_i,
  input  logic [3:0]                   pol_i,
  output logic [HW-1:0]                hsw_o,
  output logic [HW-1:0]                hbp_o,
  output logic [HW-1:0]                hfp_o,
  output logic [HW-1:0]                hact_o,
  output logic [VW-1:0]                vact_o,
  output logic [NUM_SETS-1:0][VW-1:0]  vsw_o,
  output logic [NUM_SETS-1:0][VW-1:0]  vbp_o,
  output logic [NUM_SETS-1:0][VW-1:0]  vfp_o,
  output logic [NUM_SETS-1:0]          vhalf_o,
  output logic                         interlace_o,
  output logic                         stereo_o,
  output logic [3:0]                   pol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsw_o       <= '0;
      hbp_o       <= '0;
      hfp_o       <= '0;
      hact_o      <= '0;
      vact_o      <= '0;
      interlace_o <= 1'b0;
      stereo_o    <= 1'b0;
      pol_o       <= '0;
    end else if (load_i) begin
      hsw_o       <= hsw_i;
      hbp_o       <= hbp_i;
      hfp_o       <= hfp_i;
      hact_o      <= hact_i;
      vact_o      <= vact_i;
      interlace_o <= interlace_i;
      stereo_o    <= stereo_i;
      pol_o       <= pol_i;
    end
  end

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_vset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vsw_o[k]   <= '0;
        vbp_o[k]   <= '0;
        vfp_o[k]   <= '0;
        vhalf_o[k] <= 1'b0;
      end else if (load_i) begin
        vsw_o[k]   <= vsw_i[k];
        vbp_o[k]   <= vbp_i[k];
        vfp_o[k]   <= vfp_i[k];
        vhalf_o[k] <= vhalf_i[k];
      end
    end
  end
endmodule

// File: rtl/vtg_seq.sv
`timescale 1ns/1ps
module vtg_seq import vtg_pkg::*; #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hold_i,
  input  logic [HW+1:0]                htot_i,
  input  logic [VW-1:0]                vact_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vsw_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vbp_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vfp_i,
  input  logic                         interlace_i,
  input  logic                         stereo_i,
  output logic                         run_o,
  output logic [HW+1:0]                hcnt_o,
  output logic [VW+1:0]                vcnt_o,
  output logic                         field_o,
  output logic                         eye_o,
  output logic [1:0]                   set_o,
  output logic                         frame_end_o
);
  localparam int unsigned HCW = HW + 2;
  localparam int unsigned VCW = VW + 2;

  logic [HCW-1:0] hcnt_q;
  logic [VCW-1:0] vcnt_q, vtot;
  logic           run_q, field_q, eye_q;
  logic           line_end, seg_end, nxt_field, nxt_eye;
  logic [1:0]     sel;

  always_comb begin
    sel      = set_idx(eye_q, field_q);
    vtot     = VCW'(vsw_i[sel]) + VCW'(vbp_i[sel]) + VCW'(vact_i) + VCW'(vfp_i[sel]);
    line_end = (hcnt_q == htot_i - HCW'(1));
    seg_end  = line_end && (vcnt_q == vtot - VCW'(1));
    if (stereo_i && !eye_q) begin
      nxt_eye   = 1'b1;
      nxt_field = field_q;
    end else begin
      nxt_eye   = 1'b0;
      nxt_field = interlace_i && !field_q;
    end
  end

  assign frame_end_o = run_q && seg_end && !nxt_field && !nxt_eye;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      field_q <= 1'b0;
      eye_q   <= 1'b0;
    end else if (hold_i) begin
      run_q   <= 1'b0;
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      field_q <= 1'b0;
      eye_q   <= 1'b0;
    end else if (!run_q) begin
      run_q <= 1'b1;
    end else if (line_end) begin
      hcnt_q <= '0;
      if (seg_end) begin
        vcnt_q  <= '0;
        field_q <= nxt_field;
        eye_q   <= nxt_eye;
      end else begin
        vcnt_q <= vcnt_q + VCW'(1);
      end
    end else begin
      hcnt_q <= hcnt_q + HCW'(1);
    end
  end

  assign run_o   = run_q;
  assign hcnt_o  = hcnt_q;
  assign vcnt_o  = vcnt_q;
  assign field_o = field_q;
  assign eye_o   = eye_q;
  assign set_o   = sel;
endmodule

// File: rtl/vtg_decode.sv
`timescale 1ns/1ps
module vtg_decode import vtg_pkg::*; #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW+1:0] hcnt_i,
  input  logic [VW+1:0] vcnt_i,
  input  logic          field_i,
  input  logic          eye_i,
  input  logic [HW+1:0] htot_i,
  input  logic [HW-1:0] hsw_i,
  input  logic [HW-1:0] hbp_i,
  input  logic [HW-1:0] hact_i,
  input  logic [VW-1:0] vsw_i,
  input  logic [VW-1:0] vbp_i,
  input  logic [VW-1:0] vact_i,
  input  logic          vhalf_i,
  input  logic [3:0]    pol_i,
  output logic          pclk_inv_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic          eye_o,
  output logic [HW+1:0] hcnt_o,
  output logic [VW+1:0] vcnt_o
);
  localparam int unsigned HCW = HW + 2;
  localparam int unsigned VCW = VW + 2;

  logic [HCW-1:0] h_lo, h_hi, h_half;
  logic [VCW-1:0] v_lo, v_hi, v_sw;
  logic           hs_act, vs_act, de_act;

  always_comb begin
    h_lo   = HCW'(hsw_i) + HCW'(hbp_i);
    h_hi   = h_lo + HCW'(hact_i);
    h_half = htot_i >> 1;
    v_sw   = VCW'(vsw_i);
    v_lo   = v_sw + VCW'(vbp_i);
    v_hi   = v_lo + VCW'(vact_i);
    hs_act = hcnt_i < HCW'(hsw_i);
    de_act = (hcnt_i >= h_lo) && (hcnt_i < h_hi) && (vcnt_i >= v_lo) && (vcnt_i < v_hi);
    if (vhalf_i)
      vs_act = (v_sw != '0) &&
               (((vcnt_i == '0) && (hcnt_i >= h_half)) ||
                ((vcnt_i != '0) && (vcnt_i < v_sw)) ||
                ((vcnt_i == v_sw) && (hcnt_i < h_half)));
    else
      vs_act = vcnt_i < v_sw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_inv_o <= 1'b0;
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      field_o    <= 1'b0;
      eye_o      <= 1'b0;
      hcnt_o     <= '0;
      vcnt_o     <= '0;
    end else begin
      pclk_inv_o <= pol_i[POL_CLK];
      hsync_o    <= (run_i && hs_act) ^ pol_i[POL_HS];
      vsync_o    <= (run_i && vs_act) ^ pol_i[POL_VS];
      de_o       <= (run_i && de_act) ^ pol_i[POL_DE];
      field_o    <= field_i;
      eye_o      <= eye_i;
      hcnt_o     <= hcnt_i;
      vcnt_o     <= vcnt_i;
    end
  end
endmodule

// File: rtl/video_tgen.sv
`timescale 1ns/1ps
module video_tgen import vtg_pkg::*; #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sw_rst_i,
  input  logic                         en_i,
  input  logic [HW-1:0]                hsw_i,
  input  logic [HW-1:0]                hbp_i,
  input  logic [HW-1:0]                hfp_i,
  input  logic [HW-1:0]                hact_i,
  input  logic [VW-1:0]                vact_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vsw_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vbp_i,
  input  logic [NUM_SETS-1:0][VW-1:0]  vfp_i,
  input  logic [NUM_SETS-1:0]          vhalf_i,
  input  logic                         interlace_i,
  input  logic                         stereo_i,
  input  logic [3:0]                   pol_i,
  output logic                         pclk_inv_o,
  output logic                         hsync_o,
  output logic                         vsync_o,
  output logic                         de_o,
  output logic                         field_o,
  output logic                         eye_o,
  output logic [HW+1:0]                hcnt_o,
  output logic [VW+1:0]                vcnt_o
);
  localparam int unsigned HCW = HW + 2;
  localparam int unsigned VCW = VW + 2;

  logic [HW-1:0]               s_hsw, s_hbp, s_hfp, s_hact;
  logic [VW-1:0]               s_vact;
  logic [NUM_SETS-1:0][VW-1:0] s_vsw, s_vbp, s_vfp;
  logic [NUM_SETS-1:0]         s_vhalf;
  logic                        s_intl, s_stereo;
  logic [3:0]                  s_pol;

  logic [HCW-1:0] htot, cur_h;
  logic [VCW-1:0] cur_v;
  logic           run, cur_f, cur_e, frame_end, load;
  logic [1:0]     set_sel;

  assign load = sw_rst_i | frame_end;
  assign htot = HCW'(s_hsw) + HCW'(s_hbp) + HCW'(s_hact) + HCW'(s_hfp);

  vtg_cfg_shadow #(.HW(HW), .VW(VW)) i_shadow (
    .clk_i, .rst_ni, .load_i(load),
    .hsw_i, .hbp_i, .hfp_i, .hact_i, .vact_i,
    .vsw_i, .vbp_i, .vfp_i, .vhalf_i, .interlace_i, .stereo_i, .pol_i,
    .hsw_o(s_hsw), .hbp_o(s_hbp), .hfp_o(s_hfp), .hact_o(s_hact), .vact_o(s_vact),
    .vsw_o(s_vsw), .vbp_o(s_vbp), .vfp_o(s_vfp), .vhalf_o(s_vhalf),
    .interlace_o(s_intl), .stereo_o(s_stereo), .pol_o(s_pol)
  );

  vtg_seq #(.HW(HW), .VW(VW)) i_seq (
    .clk_i, .rst_ni, .hold_i(sw_rst_i | ~en_i),
    .htot_i(htot), .vact_i(s_vact), .vsw_i(s_vsw), .vbp_i(s_vbp), .vfp_i(s_vfp),
    .interlace_i(s_intl), .stereo_i(s_stereo),
    .run_o(run), .hcnt_o(cur_h), .vcnt_o(cur_v), .field_o(cur_f), .eye_o(cur_e),
    .set_o(set_sel), .frame_end_o(frame_end)
  );

  vtg_decode #(.HW(HW), .VW(VW)) i_dec (
    .clk_i, .rst_ni, .run_i(run),
    .hcnt_i(cur_h), .vcnt_i(cur_v), .field_i(cur_f), .eye_i(cur_e),
    .htot_i(htot), .hsw_i(s_hsw), .hbp_i(s_hbp), .hact_i(s_hact),
    .vsw_i(s_vsw[set_sel]), .vbp_i(s_vbp[set_sel]), .vact_i(s_vact),
    .vhalf_i(s_vhalf[set_sel]), .pol_i(s_pol),
    .pclk_inv_o, .hsync_o, .vsync_o, .de_o, .field_o, .eye_o, .hcnt_o, .vcnt_o
  );
endmodule

// File: rtl/video_tgen_chk.sv
`timescale 1ns/1ps
module video_tgen_chk #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sw_rst_i,
  input logic          en_i,
  input logic [HW+1:0] hcnt_o,
  input logic [VW+1:0] vcnt_o,
  input logic          field_o,
  input logic          eye_o
);
  localparam int unsigned HCW = HW + 2;

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R1 R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && ($past(sw_rst_i, 2) || !$past(en_i, 2)))
      |-> (hcnt_o == '0 && vcnt_o == '0 && !field_o && !eye_o));

  // R5
  hcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_o != '0) |-> (hcnt_o == HCW'($past(hcnt_o) + 1'b1)));

  // R5
  vcnt_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vcnt_o) |-> (hcnt_o == '0));

  // R6 R8
  seg_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(field_o) || !$stable(eye_o)) |-> (hcnt_o == '0 && vcnt_o == '0));
endmodule

bind video_tgen video_tgen_chk #(.HW(HW), .VW(VW)) i_video_tgen_chk (
  .clk_i, .rst_ni, .sw_rst_i, .en_i, .hcnt_o, .vcnt_o, .field_o, .eye_o
);

// File: tb/test_video_tgen.sv
`timescale 1ns/1ps
module test_video_tgen;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_rst_i = 1'b1, en_i = 1'b0;
  logic [HW-1:0] hsw_i, hbp_i, hfp_i, hact_i;
  logic [VW-1:0] vact_i;
  logic [3:0][VW-1:0] vsw_i, vbp_i, vfp_i;
  logic [3:0] vhalf_i;
  logic interlace_i, stereo_i;
  logic [3:0] pol_i;
  logic pclk_inv_o, hsync_o, vsync_o, de_o, field_o, eye_o;
  logic [HW+1:0] hcnt_o;
  logic [VW+1:0] vcnt_o;

  always #2 clk = ~clk;

  video_tgen #(.HW(HW), .VW(VW)) i_video_tgen (
    .clk_i(clk), .rst_ni, .sw_rst_i, .en_i,
    .hsw_i, .hbp_i, .hfp_i, .hact_i, .vact_i, .vsw_i, .vbp_i, .vfp_i, .vhalf_i,
    .interlace_i, .stereo_i, .pol_i,
    .pclk_inv_o, .hsync_o, .vsync_o, .de_o, .field_o, .eye_o, .hcnt_o, .vcnt_o
  );

  int checks = 0, errors = 0;

  // driven configuration
  int c_hsw, c_hbp, c_hfp, c_hact, c_vact;
  int c_vsw[4], c_vbp[4], c_vfp[4];
  bit c_half[4];
  bit c_intl, c_st;
  bit [3:0] c_pol;
  // model configuration and state
  int m_hsw, m_hbp, m_hfp, m_hact, m_vact;
  int m_vsw[4], m_vbp[4], m_vfp[4];
  bit m_half[4];
  bit m_intl, m_st;
  bit [3:0] m_pol;
  int m_h, m_v, m_f, m_e;
  bit pend;

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic drive_cfg();
    hsw_i = HW'(c_hsw); hbp_i = HW'(c_hbp); hfp_i = HW'(c_hfp); hact_i = HW'(c_hact);
    vact_i = VW'(c_vact);
    for (int k = 0; k < 4; k++) begin
      vsw_i[k] = VW'(c_vsw[k]); vbp_i[k] = VW'(c_vbp[k]); vfp_i[k] = VW'(c_vfp[k]);
      vhalf_i[k] = c_half[k];
    end
    interlace_i = c_intl; stereo_i = c_st; pol_i = c_pol;
  endtask

  task automatic copy_cfg();
    m_hsw = c_hsw; m_hbp = c_hbp; m_hfp = c_hfp; m_hact = c_hact; m_vact = c_vact;
    for (int k = 0; k < 4; k++) begin
      m_vsw[k] = c_vsw[k]; m_vbp[k] = c_vbp[k]; m_vfp[k] = c_vfp[k]; m_half[k] = c_half[k];
    end
    m_intl = c_intl; m_st = c_st; m_pol = c_pol;
  endtask

  task automatic base_cfg();
    c_hsw = 2; c_hbp = 3; c_hact = 8; c_hfp = 2; c_vact = 4;
    for (int k = 0; k < 4; k++) begin
      c_vsw[k] = 2; c_vbp[k] = 2; c_vfp[k] = 2; c_half[k] = 1'b0;
    end
    c_intl = 1'b0; c_st = 1'b0; c_pol = 4'h0;
  endtask

  task automatic chk_idle(input string req);
    chk(hcnt_o == '0, req, "idle hcnt", int'(hcnt_o), 0);
    chk(vcnt_o == '0, req, "idle vcnt", int'(vcnt_o), 0);
    chk(!field_o && !eye_o, req, "idle field/eye", int'({field_o, eye_o}), 0);
    chk(hsync_o == m_pol[2], req, "idle hsync", int'(hsync_o), int'(m_pol[2]));
    chk(vsync_o == m_pol[3], req, "idle vsync", int'(vsync_o), int'(m_pol[3]));
    chk(de_o == m_pol[1], req, "idle de", int'(de_o), int'(m_pol[1]));
  endtask

  // hold in software reset with current config, then release
  task automatic restart(input string req);
    @(negedge clk);
    drive_cfg(); sw_rst_i = 1'b1; en_i = 1'b1;
    @(negedge clk); @(negedge clk);
    copy_cfg();
    chk_idle(req);
    sw_rst_i = 1'b0;
    @(negedge clk);
    m_h = 0; m_v = 0; m_f = 0; m_e = 0; pend = 1'b0;
  endtask

  task automatic stream(input int n, input string ctag);
    for (int i = 0; i < n; i++) begin
      int ht, idx, vt, hh, hl, vl, vs;
      bit ehs, ede, evs;
      @(negedge clk);
      ht  = m_hsw + m_hbp + m_hact + m_hfp;
      idx = m_e * 2 + m_f;
      vt  = m_vsw[idx] + m_vbp[idx] + m_vact + m_vfp[idx];
      hh  = ht / 2;
      hl  = m_hsw + m_hbp;
      vl  = m_vsw[idx] + m_vbp[idx];
      vs  = m_vsw[idx];
      ehs = m_h < m_hsw;
      ede = (m_h >= hl) && (m_h < hl + m_hact) && (m_v >= vl) && (m_v < vl + m_vact);
      if (m_half[idx])
        evs = (vs != 0) && ((m_v == 0 && m_h >= hh) || (m_v != 0 && m_v < vs) || (m_v == vs && m_h < hh));
      else
        evs = m_v < vs;
      chk(int'(hcnt_o) == m_h, ctag, "hcnt", int'(hcnt_o), m_h);
      chk(int'(vcnt_o) == m_v, ctag, "vcnt", int'(vcnt_o), m_v);
      chk(hsync_o == (ehs ^ m_pol[2]), "R2", "hsync", int'(hsync_o), int'(ehs ^ m_pol[2]));
      chk(de_o == (ede ^ m_pol[1]), "R3", "de", int'(de_o), int'(ede ^ m_pol[1]));
      chk(vsync_o == (evs ^ m_pol[3]), "R7", "vsync", int'(vsync_o), int'(evs ^ m_pol[3]));
      chk(int'(field_o) == m_f, "R6", "field", int'(field_o), m_f);
      chk(int'(eye_o) == m_e, "R8", "eye", int'(eye_o), m_e);
      // advance model
      if (m_h == ht - 1) begin
        m_h = 0;
        if (m_v == vt - 1) begin
          int nf, ne;
          m_v = 0;
          if (m_st && m_e == 0) begin ne = 1; nf = m_f; end
          else begin ne = 0; nf = m_intl ? 1 - m_f : 0; end
          if (nf == 0 && ne == 0 && pend) begin copy_cfg(); pend = 1'b0; end
          m_f = nf; m_e = ne;
        end else m_v++;
      end else m_h++;
    end
  endtask

  task automatic t_reset();
    base_cfg(); copy_cfg(); drive_cfg();
    @(negedge clk);
    chk_idle("R1");
    chk(pclk_inv_o == 1'b0, "R1", "idle pclk_inv", int'(pclk_inv_o), 0);
  endtask

  task automatic t_progressive();
    base_cfg();
    restart("R1");
    stream(2 * 150 + 20, "R5");
  endtask

  task automatic t_polarity();
    base_cfg(); c_pol = 4'hF;
    restart("R4");
    chk(pclk_inv_o == 1'b1, "R4", "pclk_inv", int'(pclk_inv_o), 1);
    stream(160, "R5");
    c_pol = 4'b0101; base_cfg(); c_pol = 4'b0101;
    restart("R4");
    chk(pclk_inv_o == 1'b1, "R4", "pclk_inv mixed", int'(pclk_inv_o), 1);
    stream(160, "R5");
  endtask

  task automatic t_interlaced();
    base_cfg(); c_intl = 1'b1; c_half[1] = 1'b1; c_vfp[1] = 3;
    restart("R6");
    stream(2 * (150 + 165) + 10, "R5");
  endtask

  task automatic t_stereo_prog();
    base_cfg(); c_st = 1'b1; c_vfp[2] = 3;
    restart("R8");
    stream(2 * (150 + 165) + 10, "R5");
  endtask

  task automatic t_stereo_intl();
    base_cfg(); c_st = 1'b1; c_intl = 1'b1;
    c_half[1] = 1'b1; c_half[3] = 1'b1;
    c_vfp[1] = 3; c_vfp[2] = 1; c_vbp[3] = 3; c_vsw[2] = 1;
    restart("R8");
    stream(4 * 165 + 60, "R5");
  endtask

  task automatic t_hold();
    base_cfg();
    restart("R1");
    stream(57, "R5");
    c_hact = 5; drive_cfg(); sw_rst_i = 1'b1;
    @(negedge clk); @(negedge clk);
    copy_cfg();
    chk_idle("R9");
    sw_rst_i = 1'b0; en_i = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk_idle("R9");
    en_i = 1'b1;
    @(negedge clk);
    m_h = 0; m_v = 0; m_f = 0; m_e = 0; pend = 1'b0;
    stream(140, "R9");
    en_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_idle("R9");
    en_i = 1'b1;
    @(negedge clk);
    m_h = 0; m_v = 0; m_f = 0; m_e = 0;
    stream(60, "R9");
  endtask

  task automatic t_frame_load();
    base_cfg(); c_intl = 1'b1;
    restart("R1");
    stream(40, "R5");
    c_hsw = 3; c_hact = 6; c_hfp = 1; c_vact = 3; c_vsw[0] = 1; c_pol = 4'b1000;
    drive_cfg(); pend = 1'b1;
    stream(2 * 150 + 2 * 135 + 30, "R10");
    chk(!pend, "R10", "new frame reached", int'(pend), 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    base_cfg(); copy_cfg(); drive_cfg();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_progressive();
    t_polarity();
    t_interlaced();
    t_stereo_prog();
    t_stereo_intl();
    t_hold();
    t_frame_load();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule